// File: doc/BRIEF.md
# Compare-Match Timer Channel

One timer channel with a word-wide register port. The channel holds a control/status register, an up-counter and a compare register. It also holds a start register that several channels share, with one run bit for each channel. A prescaler divides a slow reference strobe (`slow_tick`, one system-clock cycle wide per slow-clock edge) and so sets the counting rate. When the counter reaches the compare value, the channel sets a sticky match flag. In periodic mode the counter then restarts from zero. In free-running mode it carries on and raises an overflow flag when it rolls over from all ones.

Software sets up the channel with plain word writes and reads. It stops the channel by clearing that channel's bit in the start register. It clears the flags by writing back the value it read with the flag bits forced to zero. A value written to the counter lands only after two slow-clock edges. The interrupt line follows the match flag when the interrupt enable and the interrupt request type are both selected. No data stream passes through the block, so every pin is a plain control or status signal and there is no back-pressure.

Top module: `cmt_channel`

## Requirements
- R1: After reset, the control/status register reads 0, the counter reads 0, the compare register reads all ones, the start register reads 0 and `irq` is 0.
- R2: Channel word offsets are 0 for control/status, 1 for counter and 2 for compare. The byte address is the word offset × 4. The start register is reached with the global select. Control/status bits are:
  - 15: match flag.
  - 14: overflow flag.
  - 8: periodic mode.
  - 7: interrupt enable.
  - 5:4: request type (0 none, 1 DMA, 2 interrupt).
  - 2:0: prescale code.
  - All other bits read as 0.
- R3: Prescale codes 4, 5, 6 and 7 advance the counter once per 8, 32, 128 and 1 slow ticks. Codes 0 to 3 do not advance it.
- R4: The counter advances only while start-register bit CH_BIT is 1. Other bits of that register have no effect on this channel.
- R5: Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged and never sets it. Only hardware events set the flags.
- R6: `irq` is 1 exactly when the match flag, bit 7 and request type 2 are all present.
- R7: In periodic mode, a tick while the counter equals the compare value loads 0 and sets the match flag. A period is therefore compare + 1 ticks. The flag stays set until software clears it.
- R8: In free-running mode a match sets the flag and the counter keeps incrementing. A rollover from all ones to 0 without a match sets the overflow flag.
- R9: A written counter value is loaded at the second slow tick after the write. Reads return the old value until then, and that load replaces any count in the same cycle.
- R10: The compare register may be rewritten while the channel runs. The new value is used from the next tick.
- R11: With compare at all ones in periodic mode, the counter passes through every value and matches at all ones. It then returns to 0 with the match flag set and the overflow flag clear.
- R12: Writing 0 to the control/status register drops `irq` and clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle strobe per slow reference clock edge |
| wr_en | input | 1 | Write strobe |
| wr_glb | input | 1 | Write targets the shared start register |
| wr_addr | input | ADDR_W | Write byte address within channel space |
| wr_data | input | DATA_W | Write data |
| rd_glb | input | 1 | Read targets the shared start register |
| rd_addr | input | ADDR_W | Read byte address within channel space |
| rd_data | output | DATA_W | Combinational read data |
| irq | output | 1 | Match interrupt request |

## Verification
The bench goes after the points where a plausible design slips by one:
- Delayed counter load: a design that loaded at once, or after one slow edge, returns the new value too early.
- Prescaler phase: a divider that is not restarted on start, or that counts one extra edge, moves the match by one slow tick. The randomized period trials catch this.
- Flag clearing: a design that treats written ones as set would raise spurious flags.
- Interrupt gating: a design that ignored the request type would raise `irq` for DMA requests.
- Compare value at all ones: a design that counted the final rollover as an overflow would raise the wrong flag.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int OFS_CSR = 0;
  localparam int OFS_CNT = 1;
  localparam int OFS_CMP = 2;

  localparam logic [1:0] REQ_IRQ = 2'd2;

  typedef struct packed {
    logic       per;
    logic       ie;
    logic [1:0] req;
    logic [2:0] cks;
  } cfg_t;

  function automatic logic [15:0] csr_pack(input logic cmf, input logic ovf, input cfg_t c);
    return {cmf, ovf, 5'b0, c.per, c.ie, 1'b0, c.req, 1'b0, c.cks};
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       slow_tick,
  input  logic [2:0] cks,
  output logic       tick
);
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] lim;
  logic             valid;

  always_comb begin
    valid = 1'b1;
    case (cks)
      3'd4:    lim = PRE_W'(7);
      3'd5:    lim = PRE_W'(31);
      3'd6:    lim = PRE_W'(127);
      3'd7:    lim = '0;
      default: begin lim = '0; valid = 1'b0; end
    endcase
  end

  assign tick = run && valid && slow_tick && (pcnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pcnt <= '0;
    else if (!run || !valid)  pcnt <= '0;
    else if (slow_tick)       pcnt <= (pcnt >= lim) ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             slow_tick,
  input  logic             periodic,
  input  logic [CNT_W-1:0] cmp,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt,
  output logic             load_now,
  output logic             match_ev,
  output logic             ovf_ev
);
  logic             pend;
  logic             pend_half;
  logic [CNT_W-1:0] pend_val;
  logic             hit;

  assign load_now = pend && pend_half && slow_tick && !wr_cnt;
  assign hit      = (cnt == cmp);
  assign match_ev = tick && !load_now && hit;
  assign ovf_ev   = tick && !load_now && !hit && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_half <= 1'b0;
      pend_val  <= '0;
    end else if (wr_cnt) begin
      pend      <= 1'b1;
      pend_half <= 1'b0;
      pend_val  <= wr_val;
    end else if (pend && slow_tick) begin
      if (pend_half) pend <= 1'b0;
      pend_half <= ~pend_half;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load_now)           cnt <= pend_val;
    else if (tick && hit && periodic) cnt <= '0;
    else if (tick)               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4,
  parameter int NUM_CH = 8,
  parameter int CH_BIT = 2,
  parameter int PRE_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              wr_en,
  input  logic              wr_glb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_glb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wr_word, rd_word;
  logic              wr_csr, wr_cnt, wr_cmp, wr_strt;
  cfg_t              cfg_q;
  logic              cmf_q, ovf_q, per_q;
  logic [CNT_W-1:0]  cmp_q, cnt_q;
  logic [NUM_CH-1:0] strt_q;
  logic              run, cnt_tick, load_now, match_ev, ovf_ev;
  logic              unused_bits;

  assign wr_word = wr_addr[ADDR_W-1:2];
  assign rd_word = rd_addr[ADDR_W-1:2];
  assign wr_strt = wr_en && wr_glb;
  assign wr_csr  = wr_en && !wr_glb && (wr_word == WORD_W'(OFS_CSR));
  assign wr_cnt  = wr_en && !wr_glb && (wr_word == WORD_W'(OFS_CNT));
  assign wr_cmp  = wr_en && !wr_glb && (wr_word == WORD_W'(OFS_CMP));
  assign run     = strt_q[CH_BIT];
  assign per_q   = cfg_q.per;
  assign unused_bits = ^{wr_addr[1:0], rd_addr[1:0], wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cmp_q  <= {CNT_W{1'b1}};
      strt_q <= '0;
    end else begin
      if (wr_csr) cfg_q  <= cfg_t'({wr_data[8:7], wr_data[5:4], wr_data[2:0]});
      if (wr_cmp) cmp_q  <= wr_data[CNT_W-1:0];
      if (wr_strt) strt_q <= wr_data[NUM_CH-1:0];
    end
  end

  // Flags: hardware set wins; a written 0 clears, a written 1 keeps.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmf_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      cmf_q <= match_ev || (cmf_q && !(wr_csr && !wr_data[15]));
      ovf_q <= ovf_ev   || (ovf_q && !(wr_csr && !wr_data[14]));
    end
  end

  cmt_prescaler #(.PRE_W(PRE_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .run(run), .slow_tick(slow_tick),
    .cks(cfg_q.cks), .tick(cnt_tick)
  );

  cmt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .slow_tick(slow_tick),
    .periodic(cfg_q.per), .cmp(cmp_q), .wr_cnt(wr_cnt),
    .wr_val(wr_data[CNT_W-1:0]), .cnt(cnt_q), .load_now(load_now),
    .match_ev(match_ev), .ovf_ev(ovf_ev)
  );

  always_comb begin
    rd_data = '0;
    if (rd_glb) rd_data = DATA_W'(strt_q);
    else begin
      case (rd_word)
        WORD_W'(OFS_CSR): rd_data = DATA_W'(csr_pack(cmf_q, ovf_q, cfg_q));
        WORD_W'(OFS_CNT): rd_data = DATA_W'(cnt_q);
        WORD_W'(OFS_CMP): rd_data = DATA_W'(cmp_q);
        default:          rd_data = '0;
      endcase
    end
  end

  assign irq = cmf_q && cfg_q.ie && (cfg_q.req == REQ_IRQ);
endmodule

// File: rtl/cmt_channel_chk.sv
module cmt_channel_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             cmf_q,
  input logic             ovf_q,
  input logic             per_q,
  input logic             run,
  input logic             cnt_tick,
  input logic             load_now,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cmp_q
);
  p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cmf_q);

  p_cmf_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmf_q && !cnt_tick) |=> !cmf_q);

  p_ovf_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_q && !cnt_tick) |=> !ovf_q);

  p_stop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_now) |=> $stable(cnt_q));

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !load_now && per_q && (cnt_q == cmp_q)) |=> (cnt_q == '0) && cmf_q);

  p_rollover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !load_now && (cnt_q == {CNT_W{1'b1}}) && (cnt_q != cmp_q))
      |=> ovf_q && (cnt_q == '0));
endmodule

bind cmt_channel cmt_channel_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/cmt_channel_tb_top.sv
module cmt_channel_tb_top;
  localparam int CH = 2;
  localparam logic [3:0] A_CSR = 4'h0, A_CNT = 4'h4, A_CMP = 4'h8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        wr_en = 1'b0, wr_glb = 1'b0, rd_glb = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  cmt_channel dut_i (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .wr_glb(wr_glb), .wr_addr(wr_addr), .wr_data(wr_data), .rd_glb(rd_glb),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic glb, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_glb = glb; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_glb = 1'b0;
  endtask

  task automatic slow(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
    end
  endtask

  task automatic rd(input logic glb, input logic [3:0] a, output logic [31:0] d);
    rd_glb = glb; rd_addr = a; #1; d = rd_data;
  endtask

  function automatic int div_of(input int code);
    case (code)
      4: return 8;
      5: return 32;
      6: return 128;
      default: return 1;
    endcase
  endfunction

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, A_CSR, v); chk("R1 csr", v, 32'h0);
    rd(0, A_CNT, v); chk("R1 cnt", v, 32'h0);
    rd(0, A_CMP, v); chk("R1 cmp", v, 32'hFFFF_FFFF);
    rd(1, 4'h0, v);  chk("R1 start", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R9 delayed counter write (channel stopped)
    wr(0, A_CNT, 32'd5);
    rd(0, A_CNT, v); chk("R9 before edges", v, 32'd0);
    slow(1);
    rd(0, A_CNT, v); chk("R9 after one edge", v, 32'd0);
    slow(1);
    rd(0, A_CNT, v); chk("R9 after two edges", v, 32'd5);

    // R3 code 0 does not count
    wr(1, 4'h0, 32'(1 << CH));
    slow(3);
    rd(0, A_CNT, v); chk("R3 code0 halt", v, 32'd5);

    // R4 start bit
    wr(0, A_CSR, 32'h0000_01A7);
    wr(0, A_CMP, 32'd100);
    slow(3);
    rd(0, A_CNT, v); chk("R4 running", v, 32'd8);
    wr(1, 4'h0, 32'hFF & ~32'(1 << CH));
    rd(1, 4'h0, v); chk("R2 start readback", v, 32'hFF & ~32'(1 << CH));
    slow(3);
    rd(0, A_CNT, v); chk("R4 other bits no effect", v, 32'd8);
    wr(1, 4'h0, 32'(1 << CH));

    // R10 compare rewrite while running, R7 wrap
    wr(0, A_CMP, 32'd9);
    slow(1);
    rd(0, A_CNT, v); chk("R10 up to new cmp", v, 32'd9);
    slow(1);
    rd(0, A_CNT, v); chk("R10 R7 wrap to zero", v, 32'd0);
    rd(0, A_CSR, v); chk("R7 flag set", v, 32'h0000_81A7);
    chk("R6 irq on", {31'b0, irq}, 32'h1);

    // R5 flag write semantics
    wr(0, A_CSR, 32'h0000_81A7);
    rd(0, A_CSR, v); chk("R5 write one keeps", v, 32'h0000_81A7);
    wr(0, A_CSR, 32'h0000_01A7);
    rd(0, A_CSR, v); chk("R5 write zero clears", v, 32'h0000_01A7);
    chk("R6 irq off after clear", {31'b0, irq}, 32'h0);
    wr(0, A_CSR, 32'h0000_C1A7);
    rd(0, A_CSR, v); chk("R5 write one no set", v, 32'h0000_01A7);

    // R6 request type gating
    wr(0, A_CSR, 32'h0000_0197);
    slow(10);
    rd(0, A_CSR, v); chk("R7 R6 dma match", v, 32'h0000_8197);
    chk("R6 irq off for dma", {31'b0, irq}, 32'h0);
    slow(3);
    rd(0, A_CSR, v); chk("R7 sticky", v, 32'h0000_8197);
    wr(0, A_CSR, 32'h0000_81A7);
    chk("R6 irq with type 2", {31'b0, irq}, 32'h1);
    // R12
    wr(0, A_CSR, 32'h0);
    chk("R12 irq off", {31'b0, irq}, 32'h0);
    rd(0, A_CSR, v); chk("R12 csr zero", v, 32'h0);

    // R8 free running rollover and match
    wr(0, A_CMP, 32'd10);
    wr(0, A_CNT, 32'hFFFF_FFFE);
    slow(2);
    wr(0, A_CSR, 32'h0000_0007);
    slow(1);
    rd(0, A_CNT, v); chk("R8 at all ones", v, 32'hFFFF_FFFF);
    slow(1);
    rd(0, A_CNT, v); chk("R8 rolled", v, 32'd0);
    rd(0, A_CSR, v); chk("R8 ovf", v, 32'h0000_4007);
    slow(11);
    rd(0, A_CNT, v); chk("R8 counts past match", v, 32'd11);
    rd(0, A_CSR, v); chk("R8 match flag", v, 32'h0000_C007);

    // R11 full range compare
    wr(0, A_CSR, 32'h0000_0107);
    wr(0, A_CMP, 32'hFFFF_FFFF);
    wr(0, A_CNT, 32'hFFFF_FFFE);
    slow(2);
    rd(0, A_CNT, v); chk("R11 R9 load beats count", v, 32'hFFFF_FFFE);
    slow(1);
    rd(0, A_CNT, v); chk("R11 reaches all ones", v, 32'hFFFF_FFFF);
    slow(1);
    rd(0, A_CNT, v); chk("R11 back to zero", v, 32'd0);
    rd(0, A_CSR, v); chk("R11 match not overflow", v, 32'h0000_8107);

    // R3 R7 randomized prescaler period trials
    for (int t = 0; t < 10; t++) begin
      int code, cmpv, total;
      code  = 4 + int'($urandom % 4);
      cmpv  = int'($urandom % 6);
      total = (cmpv + 1) * div_of(code);
      wr(1, 4'h0, 32'h0);
      wr(0, A_CSR, 32'h0000_01A0 | 32'(code));
      wr(0, A_CNT, 32'd0);
      slow(2);
      wr(0, A_CMP, 32'(cmpv));
      wr(1, 4'h0, 32'(1 << CH));
      slow(total - 1);
      rd(0, A_CNT, v); chk("R3 count before period end", v, 32'(cmpv));
      rd(0, A_CSR, v); chk("R7 no flag before period end", {31'b0, v[15]}, 32'h0);
      slow(1);
      rd(0, A_CNT, v); chk("R3 R7 wrapped at period", v, 32'd0);
      rd(0, A_CSR, v); chk("R7 flag at period", {31'b0, v[15]}, 32'h1);
      chk("R6 irq at period", {31'b0, irq}, 32'h1);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule